// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

The block turns one character at a time into a serial waveform on a single output line. Software-side logic writes a data word into a one-entry holding register. On the next baud tick after the shifter is free, the word moves into the shifter and goes out one bit per baud tick. The character length is 8 or 9 bits. Parity can replace the top character bit. A single polarity control flips every level the line ever shows.

Besides data characters, the block sends a whole character time of idle (marking) level or of break (spacing) level on a one-cycle request. Baud-rate division happens upstream: the block only sees a one-clock tick per bit time. When several frames wait, the next one leaves on the tick that ends the previous stop bit, so the line has no gap.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is at logic 1, `empty_o` is 1 and `busy_o` is 0. The captured polarity control resets to non-inverted.
- R2: With `len9_i`=0 a data frame is 10 bit times: a start bit of 0, then `wdata_i[7:0]` least significant bit first, then a stop bit of 1. Each bit lasts exactly one baud-tick interval, and the first bit appears on the tick after the frame becomes pending.
- R3: With `len9_i`=1 a frame is 11 bit times. The character is `wdata_i[8:0]` sent LSB first, so `wdata_i[8]` occupies the ninth data slot when parity is off.
- R4: With `par_en_i`=1 the top character position (bit 7 in 8-bit mode, bit 8 in 9-bit mode) carries a generated parity bit instead of the written value. Parity covers the character bits below that position.
- R5: `par_odd_i`=0 makes the number of ones across the whole character, parity included, even. `par_odd_i`=1 makes it odd.
- R6: `inv_i`=1 inverts every level on `tx_o`: idle line, start, data, parity, stop and break.
- R7: A pulse on `idle_req_i` queues one character time (10 or 11 bit times, by `len9_i`) of logic 1, during which `busy_o` is 1.
- R8: A pulse on `brk_req_i` queues one character time of logic 0, stop position included.
- R9: When several items are pending at a frame start, a break goes first, then an idle preamble, then the held data word. The items not chosen stay pending.
- R10: A write is accepted only while `empty_o` is 1. A write while the holding register is full is dropped and the held word is kept.
- R11: Length, parity and polarity controls are captured at the start of each frame. Changing them mid-frame does not alter the frame in flight.
- R12: A frame pending when the current stop bit ends starts on the next tick, with no idle bit in between. The holding register reports empty from the frame-start cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud_tick_i | input | 1 | One-cycle pulse per bit time |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | BASE_W+1 | Character to send |
| len9_i | input | 1 | 0: 8-bit characters, 1: 9-bit characters |
| par_en_i | input | 1 | Parity replaces the top character bit |
| par_odd_i | input | 1 | 0: even parity, 1: odd parity |
| inv_i | input | 1 | Invert every line level |
| idle_req_i | input | 1 | Queue one idle character |
| brk_req_i | input | 1 | Queue one break character |
| empty_o | output | 1 | Holding register can take a write |
| busy_o | output | 1 | Shifter is driving a frame |
| tx_o | output | 1 | Serial output |

## Verification
The bench builds the block with its default base length of 8 bits, so both the 10-bit and 11-bit frame shapes appear, with parity at bit 7 and at bit 8. It drives a baud tick every fourth clock. That spacing leaves room to place writes, control changes and requests between ticks, so write dropping on a full holding register, mid-frame control changes, and the break-idle-data ordering of simultaneous requests can all be set up deterministically. Frames are captured one sample per tick and compared with expected bit patterns built from the requirements.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    K_DATA  = 2'd0,
    K_IDLE  = 2'd1,
    K_BREAK = 2'd2
  } kind_e;

  typedef struct packed {
    logic len9;
    logic par_en;
    logic par_odd;
    logic inv;
  } cfg_t;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  logic [DW-1:0] data_q;
  logic          full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      data_q <= data_i;
      full_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  // write into a full holder must not disturb it
  p_wr_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && wr_i && !take_i |=> full_q && $stable(data_q));
endmodule

// File: rtl/sertx_sched.sv
module sertx_sched
  import sertx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  idle_req_i,
  input  logic  brk_req_i,
  input  logic  data_full_i,
  input  logic  start_i,
  output logic  go_o,
  output kind_e kind_o
);
  logic brk_p, idle_p;
  logic take_brk, take_idle;

  always_comb begin
    if (brk_p)       kind_o = K_BREAK;
    else if (idle_p) kind_o = K_IDLE;
    else             kind_o = K_DATA;
  end

  assign take_brk  = start_i && (kind_o == K_BREAK);
  assign take_idle = start_i && (kind_o == K_IDLE);
  assign go_o      = brk_p || idle_p || data_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_p  <= 1'b0;
      idle_p <= 1'b0;
    end else begin
      brk_p  <= brk_req_i  || (brk_p  && !take_brk);
      idle_p <= idle_req_i || (idle_p && !take_idle);
    end
  end

  // an idle request waiting behind a break survives the break's launch
  p_idle_waits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && brk_p && idle_p |=> idle_p);
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int LONG_W  = BASE_W + 1,
  parameter int FRAME_W = LONG_W + 2,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [LONG_W-1:0]  data_i,
  input  cfg_t               cfg_i,
  input  kind_e              kind_i,
  output logic [FRAME_W-1:0] word_o,
  output logic [CNT_W-1:0]   nbits_o
);
  int                msb;
  logic              par;
  logic [LONG_W-1:0] ch;

  always_comb begin
    msb = cfg_i.len9 ? LONG_W - 1 : BASE_W - 1;
    ch  = data_i;
    par = cfg_i.par_odd;
    for (int i = 0; i < LONG_W - 1; i++) begin
      if (i < msb) par = par ^ data_i[i];
    end
    if (cfg_i.par_en) ch[msb] = par;

    // LSB goes first: start at bit 0, stop and filler above the character
    word_o    = '1;
    word_o[0] = 1'b0;
    for (int i = 0; i < LONG_W; i++) begin
      if (i <= msb) word_o[i+1] = ch[i];
    end
    case (kind_i)
      K_IDLE:  word_o = '1;
      K_BREAK: word_o = '0;
      default: ;
    endcase
    nbits_o = CNT_W'(msb + 3);
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int FRAME_W = 11,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               inv_i,
  output logic               start_o,
  output logic               busy_o,
  output logic               tx_o
);
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;
  logic               busy, inv_q, last;

  assign last    = busy && (cnt == CNT_W'(1));
  assign start_o = tick_i && go_i && (!busy || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg  <= '1;
      cnt   <= '0;
      busy  <= 1'b0;
      inv_q <= 1'b0;
    end else if (start_o) begin
      sreg  <= word_i;
      cnt   <= nbits_i;
      busy  <= 1'b1;
      inv_q <= inv_i;
    end else if (tick_i && busy) begin
      if (last) begin
        sreg  <= '1;
        cnt   <= '0;
        busy  <= 1'b0;
        inv_q <= inv_i;
      end else begin
        sreg <= {1'b1, sreg[FRAME_W-1:1]};
        cnt  <= cnt - CNT_W'(1);
      end
    end else if (!busy) begin
      inv_q <= inv_i;
    end
  end

  assign busy_o = busy;
  assign tx_o   = sreg[0] ^ inv_q;

  // a bit holds until the next tick
  p_bit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) && !$past(tick_i) |-> $stable(tx_o));
  // polarity is frozen for the whole frame
  p_inv_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) && !$past(start_o) |-> $stable(inv_q));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            baud_tick_i,
  input  logic            wr_i,
  input  logic [BASE_W:0] wdata_i,
  input  logic            len9_i,
  input  logic            par_en_i,
  input  logic            par_odd_i,
  input  logic            inv_i,
  input  logic            idle_req_i,
  input  logic            brk_req_i,
  output logic            empty_o,
  output logic            busy_o,
  output logic            tx_o
);
  localparam int LONG_W  = BASE_W + 1;
  localparam int FRAME_W = LONG_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [LONG_W-1:0]  hold_data;
  logic               hold_full, start, go, take;
  kind_e              kind;
  cfg_t               cfg;
  logic [FRAME_W-1:0] word;
  logic [CNT_W-1:0]   nbits;

  assign cfg  = '{len9: len9_i, par_en: par_en_i, par_odd: par_odd_i, inv: inv_i};
  assign take = start && (kind == K_DATA);

  sertx_hold #(.DW(LONG_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .data_i (wdata_i),
    .take_i (take),
    .data_o (hold_data),
    .full_o (hold_full)
  );

  sertx_sched u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_req_i  (idle_req_i),
    .brk_req_i   (brk_req_i),
    .data_full_i (hold_full),
    .start_i     (start),
    .go_o        (go),
    .kind_o      (kind)
  );

  sertx_frame #(
    .BASE_W (BASE_W),
    .LONG_W (LONG_W),
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_frame (
    .data_i  (hold_data),
    .cfg_i   (cfg),
    .kind_i  (kind),
    .word_o  (word),
    .nbits_o (nbits)
  );

  sertx_shift #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .go_i    (go),
    .word_i  (word),
    .nbits_i (nbits),
    .inv_i   (inv_i),
    .start_o (start),
    .busy_o  (busy_o),
    .tx_o    (tx_o)
  );

  assign empty_o = !hold_full;

  // first bit on the line after a launch: start/break low, idle high
  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && kind == K_DATA |=> tx_o == $past(inv_i));
  p_break_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && kind == K_BREAK |=> tx_o == $past(inv_i));
  p_idle_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && kind == K_IDLE |=> tx_o != $past(inv_i));
  // stop and filler ones above the character add len9 to the xor
  p_parity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && kind == K_DATA && par_en_i |-> (^word[FRAME_W-1:1]) == (par_odd_i ^ len9_i));
  p_data_waits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start && kind != K_DATA && hold_full |=> hold_full);
endmodule

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;
  localparam int BASE_W = 8;
  localparam int TDIV   = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic wr = 1'b0;
  logic [BASE_W:0] wdata = '0;
  logic len9 = 1'b0, pen = 1'b0, podd = 1'b0, inv = 1'b0;
  logic idle_req = 1'b0, brk_req = 1'b0;
  logic empty_o, busy_o, tx_o;
  int   n_cmp = 0, n_bad = 0;
  int   tcnt = 0;

  always #2.5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      tcnt <= 0;
      tick <= 1'b0;
    end else begin
      tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      tick <= (tcnt == TDIV - 1);
    end
  end

  sertx_top #(.BASE_W(BASE_W)) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .baud_tick_i (tick),
    .wr_i        (wr),
    .wdata_i     (wdata),
    .len9_i      (len9),
    .par_en_i    (pen),
    .par_odd_i   (podd),
    .inv_i       (inv),
    .idle_req_i  (idle_req),
    .brk_req_i   (brk_req),
    .empty_o     (empty_o),
    .busy_o      (busy_o),
    .tx_o        (tx_o)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic [8:0] d, input logic l9, input logic pe, input logic po);
    int L;
    logic [8:0] c;
    logic p;
    logic [15:0] f;
    L = l9 ? 9 : 8;
    c = d;
    if (pe) begin
      p = po;
      for (int i = 0; i < L - 1; i++) p = p ^ c[i];
      c[L-1] = p;
    end
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < L; i++) f[i+1] = c[i];
    f[L+1] = 1'b1;
    return f;
  endfunction

  function automatic int nb(input logic l9);
    return l9 ? 11 : 10;
  endfunction

  task automatic tsamp(output logic b, output logic bz);
    forever begin
      @(posedge clk_i);
      if (tick) break;
    end
    @(negedge clk_i);
    b  = tx_o;
    bz = busy_o;
  endtask

  // capture n bit times; wait for busy first when ws is set
  task automatic grab(input int n, input logic ws, output logic [15:0] bits, output logic allb);
    logic b, bz;
    int k;
    bits = '1;
    allb = 1'b1;
    k = 0;
    if (ws) begin
      for (int g = 0; g < 64; g++) begin
        tsamp(b, bz);
        if (bz) break;
      end
      bits[0] = b;
      allb = bz;
      k = 1;
    end
    for (int j = k; j < n; j++) begin
      tsamp(b, bz);
      bits[j] = b;
      allb = allb & bz;
    end
  endtask

  task automatic chk_frame(input string req, input logic [15:0] bits, input logic [15:0] exp,
                           input int n, input logic iv);
    logic [15:0] m, a, e;
    m = 16'((32'd1 << n) - 1);
    a = bits & m;
    e = (exp ^ {16{iv}}) & m;
    chk(a == e, req, a, e);
  endtask

  task automatic put(input logic [8:0] d);
    @(negedge clk_i);
    wr = 1'b1;
    wdata = d;
    @(negedge clk_i);
    wr = 1'b0;
  endtask

  task automatic expect_done(input string req, input logic idle_lvl);
    logic b, bz;
    tsamp(b, bz);
    chk(!bz && b == idle_lvl, req, {14'd0, bz, b}, {14'd0, 1'b0, idle_lvl});
  endtask

  task automatic t_reset;
    chk(tx_o == 1'b1, "R1 line high", {15'd0, tx_o}, 16'd1);
    chk(empty_o == 1'b1, "R1 empty", {15'd0, empty_o}, 16'd1);
    chk(busy_o == 1'b0, "R1 not busy", {15'd0, busy_o}, 16'd0);
  endtask

  task automatic t_basic8;
    logic [15:0] f;
    logic ab;
    len9 = 0; pen = 0; podd = 0; inv = 0;
    put(9'h1A5);
    grab(10, 1'b1, f, ab);
    chk_frame("R2 8-bit A5", f, exp_frame(9'h0A5, 0, 0, 0), 10, 0);
    expect_done("R2 length 10", 1'b1);
    put(9'h003);
    grab(10, 1'b1, f, ab);
    chk_frame("R2 8-bit 03", f, exp_frame(9'h003, 0, 0, 0), 10, 0);
    expect_done("R2 length 10b", 1'b1);
  endtask

  task automatic t_nine;
    logic [15:0] f;
    logic ab;
    len9 = 1; pen = 0;
    put(9'h155);
    grab(11, 1'b1, f, ab);
    chk_frame("R3 9-bit 155", f, exp_frame(9'h155, 1, 0, 0), 11, 0);
    expect_done("R3 length 11", 1'b1);
    len9 = 0;
  endtask

  task automatic t_parity;
    logic [15:0] f;
    logic ab;
    len9 = 0; pen = 1; podd = 0;
    put(9'h07F);  // seven ones below bit 7 -> parity 1
    grab(10, 1'b1, f, ab);
    chk_frame("R4 even parity at bit7", f, 16'b1111_1111_1111_1110, 10, 0);
    put(9'h083);  // written bit7 replaced, two ones -> parity 0
    grab(10, 1'b1, f, ab);
    chk_frame("R5 even parity 83", f, exp_frame(9'h003, 0, 0, 0), 10, 0);
    len9 = 1; podd = 1;
    put(9'h0FF);  // eight ones below bit 8 -> odd parity 1
    grab(11, 1'b1, f, ab);
    chk_frame("R5 odd parity 9-bit", f, exp_frame(9'h1FF, 1, 0, 0), 11, 0);
    len9 = 0; pen = 0; podd = 0;
  endtask

  task automatic t_inv;
    logic [15:0] f;
    logic ab;
    @(negedge clk_i);
    inv = 1;
    repeat (3) @(negedge clk_i);
    chk(tx_o == 1'b0, "R6 idle inverted", {15'd0, tx_o}, 16'd0);
    put(9'h05A);
    grab(10, 1'b1, f, ab);
    chk_frame("R6 data inverted", f, exp_frame(9'h05A, 0, 0, 0), 10, 1);
    @(negedge clk_i);
    brk_req = 1;
    @(negedge clk_i);
    brk_req = 0;
    grab(10, 1'b1, f, ab);
    chk_frame("R6 break inverted", f, 16'h0000, 10, 1);
    expect_done("R6 idle after break", 1'b0);
    @(negedge clk_i);
    inv = 0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_idle;
    logic [15:0] f;
    logic ab;
    @(negedge clk_i);
    idle_req = 1;
    @(negedge clk_i);
    idle_req = 0;
    grab(10, 1'b1, f, ab);
    chk_frame("R7 idle ones", f, 16'hFFFF, 10, 0);
    chk(ab, "R7 busy through idle", {15'd0, ab}, 16'd1);
    expect_done("R7 idle length", 1'b1);
  endtask

  task automatic t_break;
    logic [15:0] f;
    logic ab;
    len9 = 1;
    @(negedge clk_i);
    brk_req = 1;
    @(negedge clk_i);
    brk_req = 0;
    grab(11, 1'b1, f, ab);
    chk_frame("R8 break 11 zeros", f, 16'h0000, 11, 0);
    expect_done("R8 break length", 1'b1);
    len9 = 0;
  endtask

  task automatic t_prio;
    logic [15:0] f;
    logic ab;
    @(negedge clk_i);
    wr = 1; wdata = 9'h0C3; idle_req = 1; brk_req = 1;
    @(negedge clk_i);
    wr = 0; idle_req = 0; brk_req = 0;
    grab(10, 1'b1, f, ab);
    chk_frame("R9 break first", f, 16'h0000, 10, 0);
    grab(10, 1'b0, f, ab);
    chk_frame("R9 idle second", f, 16'hFFFF, 10, 0);
    grab(10, 1'b0, f, ab);
    chk_frame("R12 data back to back", f, exp_frame(9'h0C3, 0, 0, 0), 10, 0);
    expect_done("R9 queue drained", 1'b1);
  endtask

  task automatic t_full;
    logic [15:0] f;
    logic ab;
    logic b, bz;
    tsamp(b, bz);  // just after a tick, 3 clocks to the next
    wr = 1; wdata = 9'h011;
    @(negedge clk_i);
    wdata = 9'h0EE;  // held word is full here: dropped
    @(negedge clk_i);
    wr = 0;
    chk(empty_o == 1'b0, "R10 full after write", {15'd0, empty_o}, 16'd0);
    grab(10, 1'b1, f, ab);
    chk_frame("R10 first word kept", f, exp_frame(9'h011, 0, 0, 0), 10, 0);
    expect_done("R10 second write dropped", 1'b1);
  endtask

  task automatic t_b2b;
    logic [15:0] f;
    logic ab;
    logic b, bz;
    put(9'h0F0);
    for (int g = 0; g < 64; g++) begin
      tsamp(b, bz);
      if (bz) break;
    end
    f = '1;
    f[0] = b;
    chk(empty_o == 1'b1, "R12 empty at start", {15'd0, empty_o}, 16'd1);
    @(negedge clk_i);
    wr = 1; wdata = 9'h00F;
    @(negedge clk_i);
    wr = 0;
    for (int j = 1; j < 10; j++) begin
      tsamp(b, bz);
      f[j] = b;
    end
    chk_frame("R12 first of pair", f, exp_frame(9'h0F0, 0, 0, 0), 10, 0);
    grab(10, 1'b0, f, ab);
    chk_frame("R12 second with no gap", f, exp_frame(9'h00F, 0, 0, 0), 10, 0);
    expect_done("R12 pair done", 1'b1);
  endtask

  task automatic t_ctrl_hold;
    logic [15:0] f;
    logic b, bz;
    len9 = 0; pen = 0; podd = 0; inv = 0;
    put(9'h00F);
    for (int g = 0; g < 64; g++) begin
      tsamp(b, bz);
      if (bz) break;
    end
    f = '1;
    f[0] = b;
    len9 = 1; pen = 1; podd = 1; inv = 1;
    for (int j = 1; j < 10; j++) begin
      tsamp(b, bz);
      f[j] = b;
    end
    chk_frame("R11 frame unaffected", f, exp_frame(9'h00F, 0, 0, 0), 10, 0);
    len9 = 0; pen = 0; podd = 0; inv = 0;
    repeat (8) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_basic8();
    t_nine();
    t_parity();
    t_inv();
    t_idle();
    t_break();
    t_prio();
    t_full();
    t_b2b();
    t_ctrl_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule